// File: doc/BRIEF.md
# SDRAM Clock-Suspend Controller

This block owns the clock-enable pin of an SDRAM. The memory controller asks it to pause the memory in the middle of a read or write burst, and later asks it to continue. The block lowers clock-enable only while a burst is running. It reports when the memory is effectively frozen. While clock-enable is low or the freeze is in effect, it replaces every command with a no-operation. A suspend request that arrives with no burst running is refused, and the block raises a one-cycle flag for it.

The memory does no refresh of its own while suspended, so a down-counter bounds how long clock-enable may stay low. The bound is a refresh-derived cycle budget minus a safety margin. When the counter runs out, the block raises clock-enable by itself and pulses a forced-resume signal, so the refresh logic can issue a refresh at once.

The block also models the read-data valid strobe, with a latency of two or three cycles after a read. This strobe and the burst beat counter hold their state through a suspend and continue from where they stopped.

Top module: `sdram_cksusp_ctrl`

## Requirements
- R1: A suspend request in a cycle where clock-enable is high, the frozen flag is clear and a burst is active drives `cke_o` low after the next clock edge. `suspended_o` rises one cycle after `cke_o` falls.
- R2: `cke_o` stays low until a resume request or the timer limit. A resume request seen while `cke_o` is low raises it after the next edge. `suspended_o` clears one cycle after `cke_o` rises, so it is high for exactly as many cycles as `cke_o` was low.
- R3: Commands use the encoding {cs_n, ras_n, cas_n, we_n}: no-op 4'b0111, read 4'b0101, write 4'b0100, activate 4'b0011. `cmd_o` equals no-op in every cycle where `cke_o` is low or `suspended_o` is high. In all other cycles it equals `cmd_i`.
- R4: A suspend request in a cycle with `cke_o` high, `suspended_o` low and no active burst is ignored. It leaves `cke_o` high and raises `susp_reject_o` for the single following cycle.
- R5: A burst is active from the cycle a read or write passes to `cmd_o` for BURST_LEN unfrozen cycles. A suspend request in the cycle right after the last active cycle is rejected.
- R6: `cke_o` is never low for more than LIMIT = SUSP_MAX_CYC - RESUME_MARGIN consecutive cycles. When the timer ends a suspend, `force_resume_o` is high for exactly the first cycle with `cke_o` high again. A suspend ended by a resume request gives no pulse.
- R7: Without a suspend, a read gives `rd_valid_o` high for BURST_LEN cycles starting CAS_LAT cycles after the read appears on `cmd_o`. A write never raises `rd_valid_o`.
- R8: Each cycle with `suspended_o` high holds `rd_valid_o` and the beat count. The end of the valid window moves later by exactly the number of frozen cycles, and `rd_valid_o` does not change across a frozen edge.
- R9: A resume request while `cke_o` is high has no effect. A suspend request while `cke_o` is low or `suspended_o` is high neither restarts the timer nor gives a rejection.
- R10: During and after reset, `cke_o` is high and `suspended_o`, `force_resume_o`, `susp_reject_o` and `rd_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 4 | Command from the controller, {cs_n, ras_n, cas_n, we_n} |
| susp_req_i | input | 1 | Request to enter clock suspend |
| resume_req_i | input | 1 | Request to leave clock suspend |
| cmd_o | output | 4 | Command to the SDRAM, no-op while blocked |
| cke_o | output | 1 | SDRAM clock-enable pin |
| suspended_o | output | 1 | Memory internal clock is stopped |
| force_resume_o | output | 1 | One-cycle pulse when the timer ended a suspend |
| susp_reject_o | output | 1 | One-cycle pulse for a refused suspend request |
| rd_valid_o | output | 1 | Read data valid strobe |

## Verification
Each fault type shows up at the ports within a fixed number of cycles:

- A wrong timer count changes how many cycles `cke_o` stays low. It also moves or removes the forced-resume pulse, so it shows within one suspend window.
- A wrong burst counter or pipeline stage shifts the last `rd_valid_o` cycle away from CAS_LAT + BURST_LEN - 1 plus the frozen cycles. It can also refuse a suspend inside the burst or accept one just after it. Either effect is visible a few cycles after the read.
- A wrong frozen flag lets a command through while the memory cannot take it, and this is seen on `cmd_o` in the same cycle.

// File: rtl/ckss_pkg.sv
package ckss_pkg;
   typedef logic [3:0] sdr_cmd_t;

   // {cs_n, ras_n, cas_n, we_n}
   localparam sdr_cmd_t CMD_NOP   = 4'b0111;
   localparam sdr_cmd_t CMD_READ  = 4'b0101;
   localparam sdr_cmd_t CMD_WRITE = 4'b0100;
   localparam sdr_cmd_t CMD_ACT   = 4'b0011;

   function automatic logic is_rw(input sdr_cmd_t c);
      return (c == CMD_READ) || (c == CMD_WRITE);
   endfunction
endpackage

// File: rtl/ckss_burst_track.sv
module ckss_burst_track #(
   parameter int BURST_LEN = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic start_rd_i,
   input  logic freeze_i,
   output logic active_o,
   output logic rd_beat_o
);
   localparam int CW = $clog2(BURST_LEN + 1);

   logic [CW-1:0] left_q;
   logic          rd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q <= '0;
         rd_q   <= 1'b0;
      end else if (start_i) begin
         left_q <= CW'(BURST_LEN - 1);
         rd_q   <= start_rd_i;
      end else if (!freeze_i && left_q != '0) begin
         left_q <= left_q - 1'b1;
      end
   end

   assign active_o  = start_i || (left_q != '0);
   assign rd_beat_o = start_i ? start_rd_i : ((left_q != '0) && rd_q);
endmodule

// File: rtl/ckss_rdv_pipe.sv
module ckss_rdv_pipe #(
   parameter int CAS_LAT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic beat_i,
   input  logic freeze_i,
   output logic valid_o
);
   logic [CAS_LAT-1:0] stg_q;

   for (genvar g = 0; g < CAS_LAT; g++) begin : g_stage
      logic nxt;
      if (g == 0) begin : g_head
         assign nxt = beat_i;
      end else begin : g_body
         assign nxt = stg_q[g-1];
      end
      always_ff @(posedge clk) begin
         if (!rst_n)         stg_q[g] <= 1'b0;
         else if (!freeze_i) stg_q[g] <= nxt;
      end
   end

   assign valid_o = stg_q[CAS_LAT-1];
endmodule

// File: rtl/ckss_susp_timer.sv
module ckss_susp_timer #(
   parameter int LIMIT = 1544
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enter_i,
   input  logic resume_i,
   output logic cke_o,
   output logic force_o
);
   localparam int CW = $clog2(LIMIT + 1);

   logic [CW-1:0] cnt_q;
   logic          cke_q;
   logic          force_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cke_q   <= 1'b1;
         cnt_q   <= '0;
         force_q <= 1'b0;
      end else begin
         force_q <= 1'b0;
         if (cke_q) begin
            if (enter_i) begin
               cke_q <= 1'b0;
               cnt_q <= CW'(LIMIT - 1);
            end
         end else if (resume_i || cnt_q == '0) begin
            cke_q   <= 1'b1;
            force_q <= !resume_i;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign cke_o   = cke_q;
   assign force_o = force_q;
endmodule

// File: rtl/sdram_cksusp_ctrl.sv
module sdram_cksusp_ctrl #(
   parameter int BURST_LEN     = 8,
   parameter int CAS_LAT       = 3,
   parameter int SUSP_MAX_CYC  = 1560,
   parameter int RESUME_MARGIN = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] cmd_i,
   input  logic       susp_req_i,
   input  logic       resume_req_i,
   output logic [3:0] cmd_o,
   output logic       cke_o,
   output logic       suspended_o,
   output logic       force_resume_o,
   output logic       susp_reject_o,
   output logic       rd_valid_o
);
   import ckss_pkg::*;

   localparam int LIMIT = SUSP_MAX_CYC - RESUME_MARGIN;

   initial begin
      if (CAS_LAT < 2 || CAS_LAT > 3)
         $fatal(1, "CAS_LAT must be 2 or 3");
      if (BURST_LEN < 1)
         $fatal(1, "BURST_LEN must be at least 1");
      if (RESUME_MARGIN < 0 || LIMIT < 1)
         $fatal(1, "RESUME_MARGIN must leave at least one suspend cycle");
   end

   logic blocked;
   logic start;
   logic burst_act;
   logic rd_beat;
   logic enter;
   logic susp_q;
   logic rej_q;

   assign blocked = !cke_o || susp_q;
   assign cmd_o   = blocked ? CMD_NOP : cmd_i;
   assign start   = !blocked && is_rw(cmd_i);
   assign enter   = susp_req_i && !blocked && burst_act;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         susp_q <= 1'b0;
         rej_q  <= 1'b0;
      end else begin
         susp_q <= !cke_o;
         rej_q  <= susp_req_i && !blocked && !burst_act;
      end
   end

   ckss_burst_track #(.BURST_LEN(BURST_LEN)) burst_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start),
      .start_rd_i(cmd_i == CMD_READ),
      .freeze_i  (susp_q),
      .active_o  (burst_act),
      .rd_beat_o (rd_beat)
   );

   ckss_rdv_pipe #(.CAS_LAT(CAS_LAT)) pipe_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .beat_i  (rd_beat),
      .freeze_i(susp_q),
      .valid_o (rd_valid_o)
   );

   ckss_susp_timer #(.LIMIT(LIMIT)) timer_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .enter_i (enter),
      .resume_i(resume_req_i),
      .cke_o   (cke_o),
      .force_o (force_resume_o)
   );

   assign suspended_o   = susp_q;
   assign susp_reject_o = rej_q;
endmodule

// File: rtl/ckss_chk.sv
module ckss_chk #(
   parameter int LIMIT = 1544
) (
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] cmd_o,
   input logic       cke_o,
   input logic       suspended_o,
   input logic       force_resume_o,
   input logic       susp_reject_o,
   input logic       rd_valid_o,
   input logic       resume_req_i,
   input logic       burst_act
);
   int low_run;

   always_ff @(posedge clk) begin
      if (!rst_n)     low_run <= 0;
      else if (cke_o) low_run <= 0;
      else            low_run <= low_run + 1;
   end

   // R1
   entry_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cke_o) |-> $past(burst_act));
   // R1
   susp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cke_o |=> suspended_o);
   // R2
   susp_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cke_o |=> !suspended_o);
   // R2
   wake_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cke_o) |-> ($past(resume_req_i) || force_resume_o));
   // R3
   cmd_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      suspended_o |-> cmd_o == ckss_pkg::CMD_NOP);
   // R4
   reject_keeps_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
      susp_reject_o |-> (cke_o && $past(cke_o)));
   // R6
   low_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      low_run <= LIMIT);
   // R6
   force_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      force_resume_o |-> $rose(cke_o));
   // R8
   pipe_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      suspended_o |=> $stable(rd_valid_o));
endmodule

bind sdram_cksusp_ctrl ckss_chk #(.LIMIT(LIMIT)) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .cmd_o         (cmd_o),
   .cke_o         (cke_o),
   .suspended_o   (suspended_o),
   .force_resume_o(force_resume_o),
   .susp_reject_o (susp_reject_o),
   .rd_valid_o    (rd_valid_o),
   .resume_req_i  (resume_req_i),
   .burst_act     (burst_act)
);

// File: tb/sdram_cksusp_ctrl_tb_top.sv
`timescale 1ns/1ps
module sdram_cksusp_ctrl_tb_top;
   localparam int BL     = 4;
   localparam int CL     = 3;
   localparam int SMAX   = 12;
   localparam int MARGIN = 4;
   localparam int LIM    = SMAX - MARGIN;
   localparam int RUNLEN = 20;

   localparam logic [3:0] NOP = 4'b0111;
   localparam logic [3:0] RD  = 4'b0101;
   localparam logic [3:0] WR  = 4'b0100;
   localparam logic [3:0] ACT = 4'b0011;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] cmd_i = NOP;
   logic       susp_req = 1'b0;
   logic       resume_req = 1'b0;
   logic [3:0] cmd_o;
   logic       cke_o, suspended_o, force_resume_o, susp_reject_o, rd_valid_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   sdram_cksusp_ctrl #(
      .BURST_LEN(BL), .CAS_LAT(CL), .SUSP_MAX_CYC(SMAX), .RESUME_MARGIN(MARGIN)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .susp_req_i(susp_req),
      .resume_req_i(resume_req), .cmd_o(cmd_o), .cke_o(cke_o),
      .suspended_o(suspended_o), .force_resume_o(force_resume_o),
      .susp_reject_o(susp_reject_o), .rd_valid_o(rd_valid_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic idle(input int n);
      cmd_i = NOP; susp_req = 1'b0; resume_req = 1'b0;
      for (int k = 0; k < n; k++) step();
   endtask

   // one burst, suspend entered at cycle off, resumed r cycles later (r==0: timer ends it)
   task automatic run_case(input bit rd, input int off, input int r);
      int reff = (r > 0) ? r : LIM;
      int low_first = -1, low_cnt = 0, sus_first = -1, sus_cnt = 0;
      int force_at = -1, force_cnt = 0, first_v = -1, last_v = -1, rej = 0, blk_bad = 0;
      for (int i = 0; i < RUNLEN; i++) begin
         if (i == 0) cmd_i = rd ? RD : WR;
         else if (i >= off + 1 && i <= off + reff + 1) cmd_i = ACT;
         else cmd_i = NOP;
         susp_req   = (i >= off) && (i <= off + reff + 1);
         resume_req = (i < off) || (r > 0 && i == off + r);
         #1;
         if (i == 0) chk(cmd_o == cmd_i, "R3", "command passthrough", cmd_o, cmd_i);
         if (i >= off + 1 && i <= off + reff + 1 && cmd_o != NOP) blk_bad++;
         @(posedge clk);
         #0.5;
         if (!cke_o) begin if (low_first < 0) low_first = i + 1; low_cnt++; end
         if (suspended_o) begin if (sus_first < 0) sus_first = i + 1; sus_cnt++; end
         if (force_resume_o) begin force_at = i + 1; force_cnt++; end
         if (rd_valid_o) begin if (first_v < 0) first_v = i + 1; last_v = i + 1; end
         if (susp_reject_o) rej++;
         #0.5;
      end
      idle(2);
      chk(low_first == off + 1, "R1", "cke fall cycle", low_first, off + 1);
      chk(sus_first == off + 2, "R1", "suspended rise cycle", sus_first, off + 2);
      chk(low_cnt == reff, (r > 0) ? "R2" : "R6", "cke low cycles", low_cnt, reff);
      chk(sus_cnt == reff, "R2", "suspended cycles", sus_cnt, reff);
      chk(force_at == ((r == 0) ? off + LIM + 1 : -1) && force_cnt == ((r == 0) ? 1 : 0),
          "R6", "forced resume cycle", force_at, (r == 0) ? off + LIM + 1 : -1);
      chk(blk_bad == 0, "R3", "commands not blocked", blk_bad, 0);
      chk(rej == 0, "R9", "reject while suspended", rej, 0);
      if (rd) begin
         chk(last_v == CL + BL - 1 + reff, "R8", "last read valid", last_v, CL + BL - 1 + reff);
         chk(first_v >= CL, "R7", "first read valid", first_v, CL);
      end else begin
         chk(last_v == -1, "R7", "write gives read valid", last_v, -1);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int cnt_v, first_v, last_v;
      repeat (3) step();
      // R10 reset state, checked while reset is held
      chk(cke_o == 1'b1, "R10", "cke in reset", cke_o, 1);
      chk({suspended_o, force_resume_o, susp_reject_o, rd_valid_o} == 4'b0,
          "R10", "flags in reset", {suspended_o, force_resume_o, susp_reject_o, rd_valid_o}, 0);
      rst_n = 1'b1;
      step();
      chk(cke_o == 1'b1 && suspended_o == 1'b0 && rd_valid_o == 1'b0,
          "R10", "state after reset", {cke_o, suspended_o, rd_valid_o}, 3'b100);

      // R4: suspend request with no burst
      susp_req = 1'b1; step(); susp_req = 1'b0;
      chk(susp_reject_o == 1'b1, "R4", "reject pulse", susp_reject_o, 1);
      chk(cke_o == 1'b1, "R4", "cke after rejected request", cke_o, 1);
      step();
      chk(susp_reject_o == 1'b0, "R4", "reject pulse width", susp_reject_o, 0);
      chk(cke_o == 1'b1 && suspended_o == 1'b0, "R4", "no suspend after reject", cke_o, 1);

      // R9: resume request while running
      resume_req = 1'b1; step(); resume_req = 1'b0;
      chk(cke_o == 1'b1 && force_resume_o == 1'b0, "R9", "stray resume", cke_o, 1);

      // R7: plain read without suspend
      cnt_v = 0; first_v = -1; last_v = -1;
      for (int i = 0; i < 12; i++) begin
         cmd_i = (i == 0) ? RD : NOP;
         @(posedge clk); #1;
         if (rd_valid_o) begin cnt_v++; if (first_v < 0) first_v = i + 1; last_v = i + 1; end
      end
      cmd_i = NOP;
      chk(cnt_v == BL, "R7", "read valid count", cnt_v, BL);
      chk(first_v == CL, "R7", "read valid start", first_v, CL);
      chk(last_v == CL + BL - 1, "R7", "read valid end", last_v, CL + BL - 1);

      // R5: request one cycle after the burst ended is refused
      for (int i = 0; i <= BL; i++) begin
         cmd_i    = (i == 0) ? RD : NOP;
         susp_req = (i == BL);
         step();
      end
      susp_req = 1'b0;
      chk(susp_reject_o == 1'b1, "R5", "reject just after burst", susp_reject_o, 1);
      chk(cke_o == 1'b1, "R5", "cke just after burst", cke_o, 1);
      idle(10);

      // sweep: read/write, every entry offset, resume delays and timeout
      for (int rd = 0; rd < 2; rd++)
         for (int off = 0; off < BL; off++)
            for (int r = 0; r < 4; r++)
               run_case(rd[0], off, r);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule